// File: doc/BRIEF.md
# Port-Scoped Forwarding Table Flush Engine

This block owns a small forwarding table and removes entries from it on request. Software programs the match rules through a register write port: a qualifier register (VLAN id and filtering id), a mode register (match mode and entry-type selection), two port-command registers and a whole-table command register. Writing a 1 to a port's start bit queues a flush pass for that port. The engine then walks every table slot, one per cycle, and invalidates each slot that belongs to that port and satisfies the mode and type rules. Each port's busy bit reads as 1 until its own pass has finished.

Several ports can be queued at once. The engine serves them one after another, lowest port number first. A whole-table command invalidates every slot, static or not. When the engine is idle it takes a pending whole-table command before any pending port pass. A learn port writes complete entries into the table, and an observation port reads any slot out combinationally.

The engine is a three-state machine. IDLE moves to FULL_WALK when a whole-table command is pending (transition "take-full"). Otherwise it moves to PORT_WALK when any port is busy (transition "take-port"). It latches the lowest busy port and a snapshot of the qualifier and mode registers when it leaves IDLE. PORT_WALK returns to IDLE on its last slot (transition "port-done") and clears that port's busy bit. FULL_WALK returns to IDLE on its last slot (transition "full-done") and clears the whole-table busy bit.

Top module: `fdb_flush_engine`

## Requirements
- R1: After reset every register reads 0 and every table slot is invalid.
- R2: Register address 2 is the low port-command register. Writing 1 to bit p (p = 0..7) starts a pass for port p and sets busy bit 8+p. Bits 7:0 always read 0.
- R3: Register address 3 is the extended port-command register. Writing 1 to bit k (k = 0..2) starts a pass for port 8+k and sets busy bit 3+k. The other bits read 0.
- R4: A pass visits every slot exactly once, one slot per clock. When the engine is idle, a port's busy bit reads 1 from the write edge through the following SLOTS edges, and reads 0 after the edge SLOTS+1 cycles after the write.
- R5: Mode register (address 1) bits 1:0 select the match rule. Values 0 and 3 match on port alone. A slot with a different port is never touched by a port pass.
- R6: Mode value 1 additionally requires the slot VLAN id to equal qualifier bits 11:0. Mode value 2 additionally requires the slot filtering id to equal qualifier bits 15:12 (qualifier register is address 0).
- R7: Mode register bit 2 selects the entry type. With 0, only dynamic slots are cleared and static slots survive. With 1, both static and dynamic slots are cleared.
- R8: Pending ports are served one pass at a time in ascending port order. Each busy bit clears at the end of its own pass, and the next pass begins on the following edge.
- R9: A start bit written for a port whose busy bit is already 1 is ignored. The running or queued pass is neither restarted nor extended.
- R10: Writing 1 to bit 0 of address 4 invalidates every slot, static or dynamic. That bit reads 1 until the walk completes. An idle engine takes this command ahead of pending port passes.
- R11: A pass uses the qualifier, mode and type values held when it leaves IDLE. Writes made later do not affect the pass in progress.
- R12: A learn write stores a valid entry in the given slot at the next edge. It wins over a flush clearing the same slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 3 | Register write address |
| cfg_wr_data | input | 16 | Register write data |
| cfg_rd_addr | input | 3 | Register read address |
| cfg_rd_data | output | 16 | Register read data (combinational) |
| lrn_en | input | 1 | Learn write strobe |
| lrn_idx | input | $clog2(SLOTS) | Slot to write |
| lrn_static | input | 1 | Static flag of the learned entry |
| lrn_port | input | 4 | Port of the learned entry |
| lrn_vid | input | 12 | VLAN id of the learned entry |
| lrn_fid | input | 4 | Filtering id of the learned entry |
| obs_idx | input | $clog2(SLOTS) | Slot to observe |
| obs_valid | output | 1 | Valid flag of the observed slot |
| obs_static | output | 1 | Static flag of the observed slot |
| obs_port | output | 4 | Port of the observed slot |
| obs_vid | output | 12 | VLAN id of the observed slot |
| obs_fid | output | 4 | Filtering id of the observed slot |

## Verification
A start or whole-table write at edge N is visible as busy right after edge N. The walk leaves IDLE at N+1 and clears slot i at edge N+2+i. Busy reads 0 after edge N+SLOTS+1, and a queued pass starts one edge later. The bench keeps a behavioural model that applies the same edge-by-edge rules. It compares all five registers and the observed slot half a period after every rising edge. Its explicit checks are placed at edges counted from each write with these offsets, so a result one cycle early or late is reported.

// File: rtl/fdb_flush_pkg.sv
`timescale 1ns/1ps
package fdb_flush_pkg;
    localparam int NPORTS    = 11;
    localparam int LOW_PORTS = 8;
    localparam int EXT_PORTS = NPORTS - LOW_PORTS;
    localparam int PORT_W    = 4;
    localparam int VID_W     = 12;
    localparam int FID_W     = 4;
    localparam int REG_W     = 16;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] A_QUAL = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] A_LOW  = 3'd2;
    localparam logic [ADDR_W-1:0] A_EXT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_ALL  = 3'd4;

    typedef enum logic [1:0] {
        M_PORT = 2'd0,
        M_VID  = 2'd1,
        M_FID  = 2'd2,
        M_RSVD = 2'd3
    } match_mode_e;

    typedef struct packed {
        logic              valid;
        logic              stat;
        logic [PORT_W-1:0] port;
        logic [VID_W-1:0]  vid;
        logic [FID_W-1:0]  fid;
    } fdb_entry_t;

    function automatic logic [PORT_W-1:0] lowest_set(input logic [NPORTS-1:0] m);
        logic [PORT_W-1:0] r;
        r = '0;
        for (int i = NPORTS - 1; i >= 0; i--) begin
            if (m[i]) r = PORT_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/fdb_flush_regs.sv
`timescale 1ns/1ps
module fdb_flush_regs
    import fdb_flush_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [NPORTS-1:0] done_mask,
    input  logic              full_done,
    output logic [NPORTS-1:0] busy,
    output logic              full_busy,
    output logic [VID_W-1:0]  q_vid,
    output logic [FID_W-1:0]  q_fid,
    output match_mode_e       q_mode,
    output logic              q_all
);
    logic [NPORTS-1:0] start_req;
    logic              full_req;

    always_comb begin
        start_req = '0;
        if (wr_en && wr_addr == A_LOW)
            start_req[LOW_PORTS-1:0] = wr_data[LOW_PORTS-1:0];
        if (wr_en && wr_addr == A_EXT)
            start_req[NPORTS-1:LOW_PORTS] = wr_data[EXT_PORTS-1:0];
    end

    assign full_req = wr_en && (wr_addr == A_ALL) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= '0;
            full_busy <= 1'b0;
            q_vid     <= '0;
            q_fid     <= '0;
            q_mode    <= M_PORT;
            q_all     <= 1'b0;
        end else begin
            busy      <= (busy & ~done_mask) | (start_req & ~busy);
            full_busy <= (full_busy & ~full_done) | (full_req & ~full_busy);
            if (wr_en && wr_addr == A_QUAL) begin
                q_vid <= wr_data[VID_W-1:0];
                q_fid <= wr_data[VID_W+FID_W-1:VID_W];
            end
            if (wr_en && wr_addr == A_MODE) begin
                q_mode <= match_mode_e'(wr_data[1:0]);
                q_all  <= wr_data[2];
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_QUAL:  rd_data = {q_fid, q_vid};
            A_MODE:  rd_data = REG_W'({q_all, q_mode});
            A_LOW:   rd_data = REG_W'(busy[LOW_PORTS-1:0]) << LOW_PORTS;
            A_EXT:   rd_data = REG_W'(busy[NPORTS-1:LOW_PORTS]) << EXT_PORTS;
            A_ALL:   rd_data = REG_W'(full_busy);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/fdb_flush_walker.sv
`timescale 1ns/1ps
module fdb_flush_walker
    import fdb_flush_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] busy,
    input  logic              full_busy,
    input  logic [VID_W-1:0]  q_vid,
    input  logic [FID_W-1:0]  q_fid,
    input  match_mode_e       q_mode,
    input  logic              q_all,
    input  fdb_entry_t        cur_entry,
    output logic [IDX_W-1:0]  walk_idx,
    output logic              clr_en,
    output logic [NPORTS-1:0] done_mask,
    output logic              full_done
);
    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_PORT = 2'd1,
        W_FULL = 2'd2
    } walk_state_e;

    walk_state_e       state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [PORT_W-1:0] port_q;
    match_mode_e       snap_mode;
    logic              snap_all;
    logic [VID_W-1:0]  snap_vid;
    logic [FID_W-1:0]  snap_fid;
    logic              last, qual_ok, hit;

    assign walk_idx = idx_q;
    assign last     = (idx_q == IDX_W'(SLOTS - 1));

    always_comb begin
        case (snap_mode)
            M_VID:   qual_ok = (cur_entry.vid == snap_vid);
            M_FID:   qual_ok = (cur_entry.fid == snap_fid);
            default: qual_ok = 1'b1;
        endcase
    end

    assign hit = cur_entry.valid && (cur_entry.port == port_q) &&
                 (snap_all || !cur_entry.stat) && qual_ok;

    // State register, slot index and pass snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= W_IDLE;
            idx_q     <= '0;
            port_q    <= '0;
            snap_mode <= M_PORT;
            snap_all  <= 1'b0;
            snap_vid  <= '0;
            snap_fid  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == W_IDLE) begin
                idx_q <= '0;
                if (!full_busy && (|busy)) begin
                    port_q    <= lowest_set(busy);
                    snap_mode <= q_mode;
                    snap_all  <= q_all;
                    snap_vid  <= q_vid;
                    snap_fid  <= q_fid;
                end
            end else begin
                idx_q <= last ? '0 : idx_q + 1'b1;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        clr_en    = 1'b0;
        done_mask = '0;
        full_done = 1'b0;
        unique case (state_q)
            W_IDLE: begin
                if (full_busy)   state_d = W_FULL;
                else if (|busy)  state_d = W_PORT;
            end
            W_PORT: begin
                clr_en = hit;
                if (last) begin
                    done_mask = NPORTS'(1) << port_q;
                    state_d   = W_IDLE;
                end
            end
            W_FULL: begin
                clr_en = 1'b1;
                if (last) begin
                    full_done = 1'b1;
                    state_d   = W_IDLE;
                end
            end
            default: state_d = W_IDLE;
        endcase
    end
endmodule

// File: rtl/fdb_flush_table.sv
`timescale 1ns/1ps
module fdb_flush_table
    import fdb_flush_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrn_en,
    input  logic [IDX_W-1:0] lrn_idx,
    input  fdb_entry_t       lrn_entry,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] walk_idx,
    output fdb_entry_t       walk_entry,
    input  logic [IDX_W-1:0] obs_idx,
    output fdb_entry_t       obs_entry
);
    fdb_entry_t slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (lrn_en && lrn_idx == IDX_W'(g))
                slot_q[g] <= lrn_entry;
            else if (clr_en && clr_idx == IDX_W'(g))
                slot_q[g].valid <= 1'b0;
        end
    end

    assign walk_entry = slot_q[walk_idx];
    assign obs_entry  = slot_q[obs_idx];
endmodule

// File: rtl/fdb_flush_engine.sv
`timescale 1ns/1ps
module fdb_flush_engine
    import fdb_flush_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_addr,
    input  logic [REG_W-1:0]  cfg_wr_data,
    input  logic [ADDR_W-1:0] cfg_rd_addr,
    output logic [REG_W-1:0]  cfg_rd_data,
    input  logic              lrn_en,
    input  logic [IDX_W-1:0]  lrn_idx,
    input  logic              lrn_static,
    input  logic [PORT_W-1:0] lrn_port,
    input  logic [VID_W-1:0]  lrn_vid,
    input  logic [FID_W-1:0]  lrn_fid,
    input  logic [IDX_W-1:0]  obs_idx,
    output logic              obs_valid,
    output logic              obs_static,
    output logic [PORT_W-1:0] obs_port,
    output logic [VID_W-1:0]  obs_vid,
    output logic [FID_W-1:0]  obs_fid
);
    logic [NPORTS-1:0] busy_vec, done_mask;
    logic              full_busy, full_done, clr_en;
    logic [VID_W-1:0]  q_vid;
    logic [FID_W-1:0]  q_fid;
    match_mode_e       q_mode;
    logic              q_all;
    logic [IDX_W-1:0]  walk_idx;
    fdb_entry_t        walk_entry, obs_entry, lrn_entry;

    assign lrn_entry = '{valid: 1'b1, stat: lrn_static, port: lrn_port,
                         vid: lrn_vid, fid: lrn_fid};

    fdb_flush_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_addr   (cfg_wr_addr),
        .wr_data   (cfg_wr_data),
        .rd_addr   (cfg_rd_addr),
        .rd_data   (cfg_rd_data),
        .done_mask (done_mask),
        .full_done (full_done),
        .busy      (busy_vec),
        .full_busy (full_busy),
        .q_vid     (q_vid),
        .q_fid     (q_fid),
        .q_mode    (q_mode),
        .q_all     (q_all)
    );

    fdb_flush_walker #(.SLOTS(SLOTS)) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy_vec),
        .full_busy (full_busy),
        .q_vid     (q_vid),
        .q_fid     (q_fid),
        .q_mode    (q_mode),
        .q_all     (q_all),
        .cur_entry (walk_entry),
        .walk_idx  (walk_idx),
        .clr_en    (clr_en),
        .done_mask (done_mask),
        .full_done (full_done)
    );

    fdb_flush_table #(.SLOTS(SLOTS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .lrn_en     (lrn_en),
        .lrn_idx    (lrn_idx),
        .lrn_entry  (lrn_entry),
        .clr_en     (clr_en),
        .clr_idx    (walk_idx),
        .walk_idx   (walk_idx),
        .walk_entry (walk_entry),
        .obs_idx    (obs_idx),
        .obs_entry  (obs_entry)
    );

    assign obs_valid  = obs_entry.valid;
    assign obs_static = obs_entry.stat;
    assign obs_port   = obs_entry.port;
    assign obs_vid    = obs_entry.vid;
    assign obs_fid    = obs_entry.fid;
endmodule

// File: rtl/fdb_flush_checker.sv
`timescale 1ns/1ps
module fdb_flush_checker
    import fdb_flush_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [NPORTS-1:0] busy,
    input logic              full_busy,
    input logic              clr_en,
    input logic [NPORTS-1:0] done_mask,
    input logic              full_done
);
    // R2: a busy bit can only appear after a register write
    assert_busy_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> ((busy & ~$past(busy)) == '0));

    // R8: at most one port pass ends per cycle, and only for a busy port
    assert_one_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_mask) && ((done_mask & ~busy) == '0));

    // R9: a busy bit drops exactly when its own pass ends
    assert_busy_drop_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(busy) & ~busy) == $past(done_mask)));

    // R10: whole-table busy holds until its walk completes
    assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full_busy && !full_done) |=> full_busy);

    // R10: a whole-table walk never ends a port pass
    assert_full_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        full_done |-> (done_mask == '0));

    // R4: slots are cleared only while a pass is outstanding
    assert_clear_needs_work_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> (full_busy || (busy != '0)));
endmodule

bind fdb_flush_engine fdb_flush_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .busy      (busy_vec),
    .full_busy (full_busy),
    .clr_en    (clr_en),
    .done_mask (done_mask),
    .full_done (full_done)
);

// File: tb/fdb_flush_engine_tb.sv
`timescale 1ns/1ps
module fdb_flush_engine_tb;
    localparam int S = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_addr = '0;
    logic [15:0] cfg_wr_data = '0;
    logic [2:0]  cfg_rd_addr = '0;
    logic [15:0] cfg_rd_data;
    logic        lrn_en = 1'b0;
    logic [3:0]  lrn_idx = '0;
    logic        lrn_static = 1'b0;
    logic [3:0]  lrn_port = '0;
    logic [11:0] lrn_vid = '0;
    logic [3:0]  lrn_fid = '0;
    logic [3:0]  obs_idx = '0;
    logic        obs_valid, obs_static;
    logic [3:0]  obs_port, obs_fid;
    logic [11:0] obs_vid;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    logic [15:0] cap_qual, cap_mode, cap_low, cap_ext, cap_full;

    always #4 clk = ~clk;

    fdb_flush_engine #(.SLOTS(S)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .lrn_en(lrn_en), .lrn_idx(lrn_idx), .lrn_static(lrn_static),
        .lrn_port(lrn_port), .lrn_vid(lrn_vid), .lrn_fid(lrn_fid),
        .obs_idx(obs_idx), .obs_valid(obs_valid), .obs_static(obs_static),
        .obs_port(obs_port), .obs_vid(obs_vid), .obs_fid(obs_fid)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_v [S];
    bit          m_s [S];
    int          m_p [S];
    int          m_vd [S];
    int          m_fd [S];
    logic [10:0] m_pend;
    bit          m_full;
    int          m_act;   // 0 idle, 1 port pass, 2 whole pass
    int          m_pos, m_port, m_smode, m_svid, m_sfid;
    bit          m_sall;
    int          m_qvid, m_qfid, m_mode;
    bit          m_all;

    function automatic bit m_match(int i);
        bit q;
        if (m_smode == 1)      q = (m_vd[i] == m_svid);
        else if (m_smode == 2) q = (m_fd[i] == m_sfid);
        else                   q = 1'b1;
        return m_v[i] && (m_p[i] == m_port) && (m_sall || !m_s[i]) && q;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < S; i++) begin
                m_v[i] = 0; m_s[i] = 0; m_p[i] = 0; m_vd[i] = 0; m_fd[i] = 0;
            end
            m_pend = '0; m_full = 0; m_act = 0; m_pos = 0; m_port = 0;
            m_smode = 0; m_svid = 0; m_sfid = 0; m_sall = 0;
            m_qvid = 0; m_qfid = 0; m_mode = 0; m_all = 0;
        end else begin
            logic [10:0] pend0, done;
            bit full0, fdone;
            pend0 = m_pend; full0 = m_full; done = '0; fdone = 0;
            if (m_act == 1) begin
                if (m_match(m_pos)) m_v[m_pos] = 0;
                if (m_pos == S - 1) begin done[m_port] = 1'b1; m_act = 0; end
                else m_pos++;
            end else if (m_act == 2) begin
                m_v[m_pos] = 0;
                if (m_pos == S - 1) begin fdone = 1; m_act = 0; end
                else m_pos++;
            end else if (full0) begin
                m_act = 2; m_pos = 0;
            end else if (pend0 != 0) begin
                for (int p = 10; p >= 0; p--) if (pend0[p]) m_port = p;
                m_act = 1; m_pos = 0;
                m_smode = m_mode; m_sall = m_all; m_svid = m_qvid; m_sfid = m_qfid;
            end
            m_pend = pend0 & ~done;
            m_full = full0 && !fdone;
            if (cfg_wr_en) begin
                case (cfg_wr_addr)
                    3'd0: begin m_qvid = cfg_wr_data[11:0]; m_qfid = cfg_wr_data[15:12]; end
                    3'd1: begin m_mode = cfg_wr_data[1:0]; m_all = cfg_wr_data[2]; end
                    3'd2: m_pend[7:0] = m_pend[7:0] | (cfg_wr_data[7:0] & ~pend0[7:0]);
                    3'd3: m_pend[10:8] = m_pend[10:8] | (cfg_wr_data[2:0] & ~pend0[10:8]);
                    3'd4: if (cfg_wr_data[0] && !full0) m_full = 1;
                    default: ;
                endcase
            end
            if (lrn_en) begin
                m_v[lrn_idx] = 1; m_s[lrn_idx] = lrn_static; m_p[lrn_idx] = lrn_port;
                m_vd[lrn_idx] = lrn_vid; m_fd[lrn_idx] = lrn_fid;
            end
        end
    end

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, half a period after each edge
    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            cfg_rd_addr = 3'd0; #0.5;
            cap_qual = cfg_rd_data;
            cmp(cap_qual, {m_qfid[3:0], m_qvid[11:0]}, "R6 qualifier readback");
            cfg_rd_addr = 3'd1; #0.5;
            cap_mode = cfg_rd_data;
            cmp(cap_mode, {13'd0, m_all, m_mode[1:0]}, "R7 mode readback");
            cfg_rd_addr = 3'd2; #0.5;
            cap_low = cfg_rd_data;
            cmp(cap_low, {m_pend[7:0], 8'h00}, "R2 low busy readback");
            cfg_rd_addr = 3'd3; #0.5;
            cap_ext = cfg_rd_data;
            cmp(cap_ext, {10'd0, m_pend[10:8], 3'b000}, "R3 ext busy readback");
            cfg_rd_addr = 3'd4; #0.5;
            cap_full = cfg_rd_data;
            cmp(cap_full, {15'd0, m_full}, "R10 whole-table busy readback");
            if (m_v[obs_idx])
                cmp({obs_valid, obs_static, obs_port, obs_vid, obs_fid},
                    {1'b1, m_s[obs_idx], m_p[obs_idx][3:0], m_vd[obs_idx][11:0], m_fd[obs_idx][3:0]},
                    "R5 observed slot");
            else
                cmp(obs_valid, 0, "R5 observed slot valid");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic learn(input int idx, input bit st, input int port, input int vid, input int fid);
        @(negedge clk);
        lrn_en = 1'b1; lrn_idx = idx[3:0]; lrn_static = st;
        lrn_port = port[3:0]; lrn_vid = vid[11:0]; lrn_fid = fid[3:0];
        @(negedge clk);
        lrn_en = 1'b0;
    endtask

    task automatic check_slot(input int idx, input bit exp_v, input string tag);
        @(negedge clk);
        obs_idx = idx[3:0];
        #3;
        cmp(obs_valid, exp_v, tag);
    endtask

    task automatic after_edges(input int n);
        repeat (n) @(posedge clk);
        #7;
    endtask

    task automatic settle();
        repeat (22) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R1: reset state
        after_edges(1);
        cmp(cap_qual, 0, "R1 qualifier after reset");
        cmp(cap_mode, 0, "R1 mode after reset");
        cmp(cap_low, 0, "R1 low after reset");
        cmp(cap_ext, 0, "R1 ext after reset");
        cmp(cap_full, 0, "R1 whole after reset");
        for (int i = 0; i < S; i++) check_slot(i, 0, "R1 slot invalid after reset");

        // R4 R5 R7: port-only, dynamic-only pass on port 3
        learn(0, 0, 3, 10, 1);
        learn(1, 1, 3, 10, 1);
        learn(2, 0, 4, 10, 1);
        learn(3, 0, 3, 20, 2);
        learn(4, 1, 3, 20, 2);
        cfg_write(3'd2, 16'h0008);
        #3;
        cmp(cap_low, 16'h0800, "R2 busy set and start bits read zero");
        after_edges(16);
        cmp(cap_low[11], 1, "R4 busy still set after SLOTS edges");
        after_edges(1);
        cmp(cap_low[11], 0, "R4 busy cleared after SLOTS+1 edges");
        check_slot(0, 0, "R5 matching dynamic slot cleared");
        check_slot(1, 1, "R7 static slot kept with type 0");
        check_slot(2, 1, "R5 other port untouched");
        check_slot(3, 0, "R5 port-only ignores VLAN id");
        check_slot(4, 1, "R7 static slot kept with type 0");

        // R5: reserved mode value 3 behaves as port-only
        learn(5, 0, 3, 77, 5);
        cfg_write(3'd1, 16'h0003);
        cfg_write(3'd2, 16'h0008);
        settle();
        check_slot(5, 0, "R5 mode 3 acts as port-only");
        check_slot(4, 1, "R7 static kept under mode 3");

        // R6: port plus VLAN id
        learn(6, 0, 5, 100, 7);
        learn(7, 0, 5, 200, 7);
        learn(8, 0, 5, 100, 9);
        cfg_write(3'd1, 16'h0001);
        cfg_write(3'd0, {4'd0, 12'd100});
        cfg_write(3'd2, 16'h0020);
        settle();
        check_slot(6, 0, "R6 VLAN id match cleared");
        check_slot(7, 1, "R6 VLAN id mismatch kept");
        check_slot(8, 0, "R6 VLAN id match with other filtering id cleared");

        // R6: port plus filtering id
        learn(8, 0, 5, 100, 9);
        cfg_write(3'd1, 16'h0002);
        cfg_write(3'd0, {4'd7, 12'd0});
        cfg_write(3'd2, 16'h0020);
        settle();
        check_slot(7, 0, "R6 filtering id match cleared");
        check_slot(8, 1, "R6 filtering id mismatch kept");

        // R7: type 1 clears static entries as well
        cfg_write(3'd1, 16'h0004);
        cfg_write(3'd2, 16'h0008);
        settle();
        check_slot(1, 0, "R7 static cleared with type 1");
        check_slot(4, 0, "R7 static cleared with type 1");
        check_slot(2, 1, "R7 other port still kept");

        // R11: qualifier snapshot at pass start
        learn(9, 0, 6, 300, 0);
        learn(10, 0, 6, 400, 0);
        cfg_write(3'd1, 16'h0001);
        cfg_write(3'd0, {4'd0, 12'd300});
        cfg_write(3'd2, 16'h0040);
        cfg_write(3'd0, {4'd0, 12'd400});
        settle();
        check_slot(9, 0, "R11 snapshot VLAN id used");
        check_slot(10, 1, "R11 later qualifier write ignored by pass");

        // R8 R9 R3: queued ports served in order, re-start ignored
        cfg_write(3'd1, 16'h0000);
        learn(11, 0, 2, 1, 1);
        learn(12, 0, 6, 1, 1);
        learn(13, 0, 9, 1, 1);
        cfg_write(3'd2, 16'h0044);
        cfg_write(3'd3, 16'h0002);
        #3;
        cmp(cap_ext, 16'h0010, "R3 ext busy bit for port 9");
        cfg_write(3'd2, 16'h0004);
        after_edges(15);
        cmp(cap_low[10], 0, "R8 port 2 done first");
        cmp(cap_low[14], 1, "R8 port 6 still busy");
        after_edges(17);
        cmp(cap_low[14], 0, "R8 port 6 done second");
        cmp(cap_ext[4], 1, "R8 port 9 still busy");
        after_edges(17);
        cmp(cap_ext, 0, "R8 port 9 done last");
        cmp(cap_low, 0, "R9 re-start of busy port 2 ignored");
        check_slot(11, 0, "R8 port 2 slot cleared");
        check_slot(12, 0, "R8 port 6 slot cleared");
        check_slot(13, 0, "R3 port 9 slot cleared");

        // R10: whole-table flush precedence and effect
        learn(14, 1, 0, 5, 5);
        learn(15, 1, 1, 5, 5);
        cfg_write(3'd2, 16'h0001);
        cfg_write(3'd2, 16'h0002);
        cfg_write(3'd4, 16'h0001);
        after_edges(15);
        cmp(cap_low[8], 0, "R10 port 0 pass finished");
        cmp(cap_full, 1, "R10 whole-table bit reads 1 while pending");
        after_edges(17);
        cmp(cap_full, 0, "R10 whole-table walk taken before port 1");
        cmp(cap_low[9], 1, "R10 port 1 waits behind whole-table walk");
        after_edges(17);
        cmp(cap_low, 0, "R10 port 1 served afterwards");
        for (int i = 0; i < S; i++) check_slot(i, 0, "R10 every slot invalid");

        // R12: learn wins over a clear of the same slot
        cfg_write(3'd4, 16'h0001);
        repeat (15) @(negedge clk);
        learn(15, 0, 7, 123, 3);
        settle();
        check_slot(15, 1, "R12 learn wins over clear");
        cmp(obs_port, 7, "R12 learned port");
        cmp(obs_vid, 123, "R12 learned VLAN id");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule